// File: doc/BRIEF.md
# Strobed Parallel Port

This block is one 8-bit parallel port of a programmable peripheral interface, together with the handshake lines and status bits that belong to it. A host reaches it through a small synchronous register interface with three addresses: the data port, a status byte, and a control word. The control word either sets the operating mode or sets or clears a single status bit. In basic mode the port is a plain input or output with no handshake. In strobed mode it moves one byte at a time under a two-wire handshake. As an input, an external strobe loads a byte and raises a buffer-full flag. As an output, a host write raises an active-low output-full flag and an external acknowledge clears it. In both strobed directions an interrupt request can be raised at the end of each transfer.

The strobe and acknowledge lines and the input pins are brought into the clock domain through a synchronizer of configurable depth. The data pins pass through the same number of stages as the strobe, so a byte is captured exactly as it stood at the strobe's rising edge. Host read and write strobes are active-low levels that are sampled each clock. The rising and falling edges of these strobes drive the flag logic.

Top module: `pp_strobe_port`

## Requirements
- R1: After reset the port is in basic mode with input direction. In this state ibf=0, obf_n=1, intr=0, pin_oe=0 and pin_out=0, and the status byte reads 0x00.
- R2: A write to the control address (addr=3) with bit 7 set is a mode set. Bits 6:5 select the mode: 00 is basic, 01 is strobed, and 10 or 11 is treated as basic. Bit 4 selects the direction, with 1 meaning input and 0 meaning output. pin_oe is high exactly when the direction is output. A mode set clears ibf, intr and the interrupt enable, sets obf_n to 1, and resets pin_out to 0.
- R3: A control write with bit 7 clear is a single-bit set/reset. Bits 3:1 give the bit number and bit 0 gives the new value. Only bit 4 in strobed input mode and bit 6 in strobed output mode change the interrupt enable. Every other bit number has no effect.
- R4: In basic mode a data read (addr=0) returns the pins when the direction is input. A data write loads pin_out when the direction is output. The strobe and acknowledge lines never change ibf, obf_n or intr.
- R5: In strobed input mode, a falling edge on stb_n sets ibf. The byte on pin_in at the rising edge of stb_n is captured, and data reads return that byte.
- R6: In strobed input mode, a rising edge on stb_n sets intr only while the interrupt enable is set.
- R7: In strobed input mode, the falling edge of rd_n during a data read clears intr, and the rising edge of rd_n clears ibf.
- R8: In strobed output mode, the falling edge of wr_n during a data write clears intr and loads the byte onto pin_out. The rising edge of wr_n drives obf_n low.
- R9: In strobed output mode, a falling edge on ack_n returns obf_n high. A rising edge on ack_n sets intr only while the interrupt enable is set.
- R10: The status byte (addr=1) has intr at bit 3. In strobed input mode it has ibf at bit 5 and the enable at bit 4. In strobed output mode it has obf_n at bit 7 and the enable at bit 6. All other bits are 0, and the whole byte is 0x00 in basic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 data, 1 status, 3 control |
| wdata | input | DW | Host write data |
| wr_n | input | 1 | Host write strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| rdata | output | DW | Registered host read data |
| pin_in | input | DW | External data pins, input side |
| pin_out | output | DW | External data pins, output side |
| pin_oe | output | 1 | Output enable for the data pins |
| stb_n | input | 1 | External input strobe, active low |
| ibf | output | 1 | Input buffer full |
| ack_n | input | 1 | External output acknowledge, active low |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request |

## Verification
The bench builds the port with DW=8 and SYNC_STAGES=2. This puts every edge of strobe and acknowledge a fixed three clocks from the pin, so the bench can change the data pins one clock after the strobe rises and still confirm that the earlier byte is the one captured. With two stages, a full strobed transfer fits in a few dozen cycles. This leaves room to walk each mode, the enable set and reset on both relevant bit numbers, the ignored bit numbers, and both values of the mode field that fall back to basic.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    PM_BASIC  = 2'b00,
    PM_STROBE = 2'b01,
    PM_BIDIR  = 2'b10,
    PM_BIDIR2 = 2'b11
  } pmode_e;

  localparam logic [1:0] A_DATA = 2'b00;
  localparam logic [1:0] A_STAT = 2'b01;
  localparam logic [1:0] A_CTRL = 2'b11;

  // status bit positions that also name the enable bit for set/reset
  localparam int IN_INTE_BIT  = 4;
  localparam int OUT_INTE_BIT = 6;
  localparam int IBF_BIT      = 5;
  localparam int OBF_BIT      = 7;
  localparam int INTR_BIT     = 3;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter bit RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= {W{RST_ONE}};
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pp_cfg.sv
module pp_cfg
  import pp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctrl,
  input  logic [7:0] cword,
  output logic       mode_set,
  output logic       hs_in,
  output logic       hs_out,
  output logic       dir_in,
  output logic       inte
);
  pmode_e mode_q;
  logic   strobed;

  assign mode_set = wr_ctrl & cword[7];
  assign strobed  = (mode_q == PM_STROBE);
  assign hs_in    = strobed & dir_in;
  assign hs_out   = strobed & ~dir_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PM_BASIC;
      dir_in <= 1'b1;
      inte   <= 1'b0;
    end else if (mode_set) begin
      mode_q <= pmode_e'(cword[6:5]);
      dir_in <= cword[4];
      inte   <= 1'b0;
    end else if (wr_ctrl) begin
      if (hs_in && cword[3:1] == 3'(IN_INTE_BIT))
        inte <= cword[0];
      else if (hs_out && cword[3:1] == 3'(OUT_INTE_BIT))
        inte <= cword[0];
    end
  end
endmodule

// File: rtl/pp_hshake.sv
module pp_hshake #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          hs_in,
  input  logic          hs_out,
  input  logic          inte,
  input  logic          stb_fall,
  input  logic          stb_rise,
  input  logic          ack_fall,
  input  logic          ack_rise,
  input  logic          rd_fall,
  input  logic          rd_rise,
  input  logic          wr_fall,
  input  logic          wr_rise,
  input  logic [DW-1:0] din,
  output logic          ibf,
  output logic          obf_n,
  output logic          intr,
  output logic [DW-1:0] in_latch
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ibf      <= 1'b0;
      obf_n    <= 1'b1;
      intr     <= 1'b0;
      in_latch <= '0;
    end else if (hs_in) begin
      obf_n <= 1'b1;
      if (stb_fall)     ibf <= 1'b1;
      else if (rd_rise) ibf <= 1'b0;
      if (stb_rise) in_latch <= din;
      if (stb_rise && inte) intr <= 1'b1;
      else if (rd_fall)     intr <= 1'b0;
    end else if (hs_out) begin
      ibf <= 1'b0;
      if (wr_rise)       obf_n <= 1'b0;
      else if (ack_fall) obf_n <= 1'b1;
      if (ack_rise && inte) intr <= 1'b1;
      else if (wr_fall)     intr <= 1'b0;
    end else begin
      ibf   <= 1'b0;
      obf_n <= 1'b1;
      intr  <= 1'b0;
    end
  end
endmodule

// File: rtl/pp_strobe_port.sv
module pp_strobe_port
  import pp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_n,
  input  logic          rd_n,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic          pin_oe,
  input  logic          stb_n,
  output logic          ibf,
  input  logic          ack_n,
  output logic          obf_n,
  output logic          intr
);
  localparam int CW = 8;

  logic [1:0]    hs_sync, hs_prev;
  logic [DW-1:0] din_sync;
  logic          wr_q, rd_q;
  logic          wr_fall, wr_rise, rd_fall, rd_rise, sel_data;
  logic          stb_fall, stb_rise, ack_fall, ack_rise;
  logic          mode_set, hs_in, hs_out, dir_in, inte;
  logic [DW-1:0] in_latch, out_latch, rd_mux;
  logic [CW-1:0] status;

  pp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_hs_sync (
    .clk(clk), .rst(rst), .d({stb_n, ack_n}), .q(hs_sync));

  pp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_din_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(din_sync));

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_prev <= 2'b11;
      wr_q    <= 1'b1;
      rd_q    <= 1'b1;
    end else begin
      hs_prev <= hs_sync;
      wr_q    <= wr_n;
      rd_q    <= rd_n;
    end
  end

  assign stb_fall = hs_prev[1] & ~hs_sync[1];
  assign stb_rise = ~hs_prev[1] & hs_sync[1];
  assign ack_fall = hs_prev[0] & ~hs_sync[0];
  assign ack_rise = ~hs_prev[0] & hs_sync[0];
  assign sel_data = (addr == A_DATA);
  assign wr_fall  = wr_q & ~wr_n;
  assign wr_rise  = ~wr_q & wr_n;
  assign rd_fall  = rd_q & ~rd_n;
  assign rd_rise  = ~rd_q & rd_n;

  pp_cfg u_cfg (
    .clk(clk), .rst(rst),
    .wr_ctrl(wr_fall && addr == A_CTRL), .cword(wdata[CW-1:0]),
    .mode_set(mode_set), .hs_in(hs_in), .hs_out(hs_out),
    .dir_in(dir_in), .inte(inte));

  pp_hshake #(.DW(DW)) u_hs (
    .clk(clk), .rst(rst), .clr(mode_set),
    .hs_in(hs_in), .hs_out(hs_out), .inte(inte),
    .stb_fall(stb_fall), .stb_rise(stb_rise),
    .ack_fall(ack_fall), .ack_rise(ack_rise),
    .rd_fall(rd_fall && sel_data), .rd_rise(rd_rise && sel_data),
    .wr_fall(wr_fall && sel_data), .wr_rise(wr_rise && sel_data),
    .din(din_sync),
    .ibf(ibf), .obf_n(obf_n), .intr(intr), .in_latch(in_latch));

  always_ff @(posedge clk) begin
    if (rst || mode_set)
      out_latch <= '0;
    else if (wr_fall && sel_data && !dir_in)
      out_latch <= wdata;
  end

  assign pin_out = out_latch;
  assign pin_oe  = ~dir_in;

  always_comb begin
    status = '0;
    if (hs_in) begin
      status[IBF_BIT]     = ibf;
      status[IN_INTE_BIT] = inte;
      status[INTR_BIT]    = intr;
    end else if (hs_out) begin
      status[OBF_BIT]      = obf_n;
      status[OUT_INTE_BIT] = inte;
      status[INTR_BIT]     = intr;
    end
  end

  always_comb begin
    case (addr)
      A_DATA:  rd_mux = hs_in ? in_latch : (dir_in ? din_sync : out_latch);
      A_STAT:  rd_mux = DW'(status);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (!rd_n) rdata <= rd_mux;
  end
endmodule

// File: rtl/pp_strobe_port_chk.sv
module pp_strobe_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ibf,
  input logic          obf_n,
  input logic          intr,
  input logic          pin_oe,
  input logic [DW-1:0] pin_out,
  input logic          wr_n,
  input logic          mode_set,
  input logic          inte
);
  // R2
  mode_set_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mode_set |=> (!ibf && obf_n && !intr && pin_out == '0));

  // R5
  one_dir_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !(ibf && !obf_n));

  // R2
  ibf_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    ibf |-> !pin_oe);

  // R6
  intr_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(intr) |-> $past(inte));

  // R8
  obf_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(obf_n) |-> $past(wr_n));
endmodule

bind pp_strobe_port pp_strobe_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ibf(ibf), .obf_n(obf_n), .intr(intr),
  .pin_oe(pin_oe), .pin_out(pin_out), .wr_n(wr_n),
  .mode_set(mode_set), .inte(inte));

// File: tb/sim_pp_strobe_port.sv
module sim_pp_strobe_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 0, rst = 1;
  logic [1:0] addr = 0;
  logic [DW-1:0] wdata = 0, pin_in = 0;
  logic wr_n = 1, rd_n = 1, stb_n = 1, ack_n = 1;
  logic [DW-1:0] rdata, pin_out;
  logic pin_oe, ibf, obf_n, intr;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_strobe_port #(.DW(DW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_n(wr_n),
    .rd_n(rd_n), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .stb_n(stb_n), .ibf(ibf), .ack_n(ack_n),
    .obf_n(obf_n), .intr(intr));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_n = 0; cyc(2);
    wr_n = 1; cyc(2);
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_n = 0; cyc(2);
    d = rdata; rd_n = 1; cyc(2);
  endtask

  task automatic strobe(input logic [7:0] d);
    pin_in = d; stb_n = 0; cyc(6);
    stb_n = 1; cyc(1);
    pin_in = ~d; cyc(6);
  endtask

  task automatic ackpulse();
    ack_n = 0; cyc(6);
    chk("R9 obf_n released on ack low", {7'b0, obf_n}, 8'h01);
    ack_n = 1; cyc(6);
  endtask

  task automatic t_reset();
    chk("R1 ibf", {7'b0, ibf}, 8'h00);
    chk("R1 obf_n", {7'b0, obf_n}, 8'h01);
    chk("R1 intr", {7'b0, intr}, 8'h00);
    chk("R1 pin_oe", {7'b0, pin_oe}, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    hread(2'd1, rv); chk("R1 status", rv, 8'h00);
  endtask

  task automatic t_basic();
    hwrite(2'd3, 8'h80);
    chk("R2 basic output oe", {7'b0, pin_oe}, 8'h01);
    hwrite(2'd0, 8'h5A);
    chk("R4 basic write pins", pin_out, 8'h5A);
    strobe(8'h11);
    chk("R4 no ibf in basic", {7'b0, ibf}, 8'h00);
    ack_n = 0; cyc(6); ack_n = 1; cyc(6);
    chk("R4 no intr in basic", {7'b0, intr}, 8'h00);
    hread(2'd1, rv); chk("R10 basic status zero", rv, 8'h00);
    hwrite(2'd3, 8'h90);
    chk("R2 basic input oe", {7'b0, pin_oe}, 8'h00);
    chk("R2 latch cleared by mode set", pin_out, 8'h00);
    pin_in = 8'hC3; cyc(4);
    hread(2'd0, rv); chk("R4 basic read pins", rv, 8'hC3);
  endtask

  task automatic t_strobed_in();
    hwrite(2'd3, 8'hB0);
    hread(2'd1, rv); chk("R10 strobed input status idle", rv, 8'h00);
    hwrite(2'd3, 8'h09);
    hread(2'd1, rv); chk("R3 enable set via bit 4", rv, 8'h10);
    pin_in = 8'hA5; stb_n = 0; cyc(6);
    chk("R5 ibf on stb low", {7'b0, ibf}, 8'h01);
    chk("R6 no intr before stb rise", {7'b0, intr}, 8'h00);
    stb_n = 1; cyc(1); pin_in = 8'h3C; cyc(6);
    chk("R6 intr on stb rise", {7'b0, intr}, 8'h01);
    hread(2'd1, rv); chk("R10 status ibf inte intr", rv, 8'h38);
    addr = 2'd0; rd_n = 0; cyc(2);
    chk("R5 captured at stb rise", rdata, 8'hA5);
    chk("R7 intr cleared on read fall", {7'b0, intr}, 8'h00);
    chk("R7 ibf held during read", {7'b0, ibf}, 8'h01);
    rd_n = 1; cyc(2);
    chk("R7 ibf cleared on read rise", {7'b0, ibf}, 8'h00);
    hwrite(2'd3, 8'h08);
    hwrite(2'd3, 8'h0D);
    hread(2'd1, rv); chk("R3 bit 6 ignored in input", rv, 8'h00);
    strobe(8'h66);
    chk("R6 no intr while disabled", {7'b0, intr}, 8'h00);
    chk("R5 ibf set without enable", {7'b0, ibf}, 8'h01);
    hread(2'd0, rv); chk("R5 second byte", rv, 8'h66);
  endtask

  task automatic t_strobed_out();
    hwrite(2'd3, 8'hA0);
    chk("R2 strobed output oe", {7'b0, pin_oe}, 8'h01);
    hread(2'd1, rv); chk("R10 output status idle", rv, 8'h80);
    hwrite(2'd3, 8'h09);
    hread(2'd1, rv); chk("R3 bit 4 ignored in output", rv, 8'h80);
    hwrite(2'd3, 8'h0D);
    hread(2'd1, rv); chk("R3 enable set via bit 6", rv, 8'hC0);
    hwrite(2'd0, 8'h3C);
    chk("R8 data on pins", pin_out, 8'h3C);
    chk("R8 obf_n low after write", {7'b0, obf_n}, 8'h00);
    ackpulse();
    chk("R9 intr on ack rise", {7'b0, intr}, 8'h01);
    hread(2'd1, rv); chk("R10 output status full", rv, 8'hC8);
    addr = 2'd0; wdata = 8'h77; wr_n = 0; cyc(2);
    chk("R8 intr cleared on write fall", {7'b0, intr}, 8'h00);
    chk("R8 obf_n waits for write rise", {7'b0, obf_n}, 8'h01);
    wr_n = 1; cyc(2);
    chk("R8 obf_n low on write rise", {7'b0, obf_n}, 8'h00);
    hwrite(2'd3, 8'hA0);
    chk("R2 mode set releases obf", {7'b0, obf_n}, 8'h01);
    chk("R2 mode set clears latch", pin_out, 8'h00);
  endtask

  task automatic t_bidir_as_basic();
    hwrite(2'd3, 8'hD0);
    strobe(8'h42);
    chk("R2 mode 10 acts basic", {7'b0, ibf}, 8'h00);
    hwrite(2'd3, 8'hE0);
    hread(2'd1, rv); chk("R2 mode 11 acts basic", rv, 8'h00);
    chk("R2 mode 11 output oe", {7'b0, pin_oe}, 8'h01);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    cyc(3); rst = 0; cyc(2);
    t_reset();
    t_basic();
    t_strobed_in();
    t_strobed_out();
    t_bidir_as_basic();
    done = 1;
    finish_run();
  end
endmodule